// File: doc/BRIEF.md
# A/D Converter Control Register with Clock Prescaler

This block is the single 8-bit setup register that sits beside an on-chip A/D converter. Software writes it over a plain write strobe and reads it back combinationally. It holds four settings: the conversion clock rate, the reference source, the power request for the internal 1.25 V bandgap, and the routing of that bandgap onto the converter input. From these settings it drives the control lines of the analog side. It also produces a clock-enable pulse for the converter at the selected fraction of the system clock.

The bandgap is powered whenever the converter asks for it or either low-voltage supervisor (reset or detect) is active. The bandgap needs time to settle after the converter's request turns on. A parameterised timer therefore keeps a ready flag low for that interval and drops conversion-start requests until the interval has passed. The top clock-select code has no defined rate. It runs at the slowest rate and sets a sticky flag.

Top module: `adc_ctrl_reg`

## Requirements
- R1: A write (`wr_en` high at a rising clock edge) loads `wdata`. From the next cycle `rdata` shows the stored value. The field layout is: bit 7 = bandgap routing, bit 6 = bandgap request, bit 4 = external reference, bits 2..0 = clock select.
- R2: Bits 5 and 3 ignore writes and always read as 0.
- R3: While `rst_n` is low, every stored bit, the invalid flag and the settle timer are cleared.
- R4: `adc_tick` is high in one cycle out of every N. N is 1, 2, 4, 8, 16, 32 or 64 for select codes 0 to 6. The tick falls in the last cycle of each N-cycle window, counted from reset.
- R5: Select code 7 divides by 64. It sets `sel_invalid`, which stays high until reset.
- R6: `bg_route` (bandgap onto the converter, all other channels cut off) is high only when bits 7 and 6 are both set.
- R7: `bg_power` is high when bit 6, `lvr_en` or `lvd_en` is high. Otherwise it is low.
- R8: `bg_ready` goes high SETTLE_CYCLES cycles after the write that sets bit 6 from 0. It drops in the cycle after bit 6 is cleared, and the timer restarts on the next 0-to-1 change.
- R9: `conv_start` follows `conv_req` when bit 6 is clear or `bg_ready` is high. Otherwise it is held low.
- R10: `ref_ext` and `pin_ovr` both equal bit 4. A 1 selects the external reference pin and turns off that pin's other functions. A 0 selects the supply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Write data |
| lvr_en | input | 1 | Low-voltage reset active |
| lvd_en | input | 1 | Low-voltage detect active |
| conv_req | input | 1 | Conversion start request |
| rdata | output | 8 | Register readback |
| adc_tick | output | 1 | Converter clock enable |
| sel_invalid | output | 1 | Sticky flag for the undefined clock code |
| bg_power | output | 1 | Bandgap power enable |
| bg_route | output | 1 | Bandgap routed to the converter, other channels off |
| ref_ext | output | 1 | External reference selected |
| pin_ovr | output | 1 | Shared reference pin taken from its other functions |
| bg_ready | output | 1 | Bandgap settled for converter use |
| conv_start | output | 1 | Gated conversion start |

## Verification
The bench runs every clock-select code long enough to cover several windows. A prescaler with an off-by-one mask would tick at the wrong phase or rate. Code 7 is written so that a design that stops the clock or lets the flag fall back is caught. Bit 7 is set with bit 6 clear to catch routing that ignores the bandgap request. Bit 6 is cleared in the middle of the settle window and then set again, to catch a timer that does not restart. Conversion requests are applied during the settle window and with the request bit clear, to catch gating that leaks or over-blocks.

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg #(
  parameter int SETTLE_CYCLES = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       lvr_en,
  input  logic       lvd_en,
  input  logic       conv_req,
  output logic [7:0] rdata,
  output logic       adc_tick,
  output logic       sel_invalid,
  output logic       bg_power,
  output logic       bg_route,
  output logic       ref_ext,
  output logic       pin_ovr,
  output logic       bg_ready,
  output logic       conv_start
);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam int DW = 6;
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYCLES);

  logic          route_q, bgen_q, refx_q, inv_q;
  logic [2:0]    sel_q, eff_sel;
  logic [SW-1:0] settle_q;
  logic [DW-1:0] div_q, win_mask;
  logic          settled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= 1'b0;
      bgen_q  <= 1'b0;
      refx_q  <= 1'b0;
      sel_q   <= '0;
      inv_q   <= 1'b0;
    end else if (wr_en) begin
      route_q <= wdata[7];
      bgen_q  <= wdata[6];
      refx_q  <= wdata[4];
      sel_q   <= wdata[2:0];
      inv_q   <= inv_q | (&wdata[2:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      settle_q <= '0;
    else if (!bgen_q)
      settle_q <= '0;
    else if (!settled)
      settle_q <= settle_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  assign eff_sel  = (&sel_q) ? 3'd6 : sel_q;
  assign win_mask = ~({DW{1'b1}} << eff_sel);
  assign adc_tick = &(div_q | ~win_mask);

  assign settled     = (settle_q == SETTLE_LAST);
  assign bg_ready    = bgen_q & settled;
  assign conv_start  = conv_req & (~bgen_q | settled);
  assign bg_power    = bgen_q | lvr_en | lvd_en;
  assign bg_route    = route_q & bgen_q;
  assign ref_ext     = refx_q;
  assign pin_ovr     = refx_q;
  assign sel_invalid = inv_q;
  assign rdata       = {route_q, bgen_q, 1'b0, refx_q, 1'b0, sel_q};
endmodule

// File: rtl/adc_ctrl_reg_chk.sv
module adc_ctrl_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic       lvr_en,
  input logic       lvd_en,
  input logic       conv_req,
  input logic [7:0] rdata,
  input logic       sel_invalid,
  input logic       bg_power,
  input logic       bg_route,
  input logic       bg_ready,
  input logic       conv_start
);
  // R1
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rdata == ($past(wdata) & 8'hD7));
  // R2
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata[5] && !rdata[3]);
  // R5
  inv_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_invalid |=> sel_invalid);
  // R6
  route_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bg_route |-> bg_power && rdata[6]);
  // R8
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdata[6]) |-> !bg_ready);
  // R8
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bg_ready) |-> $stable(rdata[6]));
  // R9
  start_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> conv_req && (bg_ready || !rdata[6]));
  // R7
  power_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvr_en || lvd_en) |-> bg_power);
endmodule

bind adc_ctrl_reg adc_ctrl_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
  .lvr_en(lvr_en), .lvd_en(lvd_en), .conv_req(conv_req),
  .rdata(rdata), .sel_invalid(sel_invalid), .bg_power(bg_power),
  .bg_route(bg_route), .bg_ready(bg_ready), .conv_start(conv_start)
);

// File: tb/tb_adc_ctrl_reg.sv
module tb_adc_ctrl_reg;
  localparam int SETTLE = 20;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic lvr_en = 1'b0, lvd_en = 1'b0, conv_req = 1'b0;
  logic [7:0] rdata;
  logic adc_tick, sel_invalid, bg_power, bg_route, ref_ext, pin_ovr, bg_ready, conv_start;

  int checks = 0, errors = 0;
  bit started = 0, done = 0;

  adc_ctrl_reg #(.SETTLE_CYCLES(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
    .lvr_en(lvr_en), .lvd_en(lvd_en), .conv_req(conv_req),
    .rdata(rdata), .adc_tick(adc_tick), .sel_invalid(sel_invalid),
    .bg_power(bg_power), .bg_route(bg_route), .ref_ext(ref_ext),
    .pin_ovr(pin_ovr), .bg_ready(bg_ready), .conv_start(conv_start));

  always #2 clk = ~clk;

  // behavioural model
  bit [7:0] m_reg = 0;
  bit m_inv = 0;
  longint cyc = 0, t_on = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg = 0; m_inv = 0; cyc = 0; t_on = 0;
    end else begin
      cyc++;
      if (wr_en) begin
        if (wdata[6] && !m_reg[6]) t_on = cyc;
        m_reg = wdata & 8'hD7;
        if (wdata[2:0] == 3'd7) m_inv = 1;
      end
    end
    started = 1;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cyc %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      int n;
      bit rdy;
      n = 1 << ((m_reg[2:0] == 3'd7) ? 6 : m_reg[2:0]);
      rdy = m_reg[6] && (cyc - t_on >= SETTLE);
      chk("R1/R2/R3 rdata", rdata, m_reg);
      chk("R4 adc_tick", {7'd0, adc_tick}, {7'd0, (cyc % n) == n - 1});
      chk("R5 sel_invalid", {7'd0, sel_invalid}, {7'd0, m_inv});
      chk("R6 bg_route", {7'd0, bg_route}, {7'd0, m_reg[7] && m_reg[6]});
      chk("R7 bg_power", {7'd0, bg_power}, {7'd0, m_reg[6] || lvr_en || lvd_en});
      chk("R8 bg_ready", {7'd0, bg_ready}, {7'd0, rdy});
      chk("R9 conv_start", {7'd0, conv_start}, {7'd0, conv_req && (!m_reg[6] || rdy)});
      chk("R10 ref/pin", {6'd0, ref_ext, pin_ovr}, {6'd0, m_reg[4], m_reg[4]});
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      wr_en = 0;
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); #1;
    wr_en = 1; wdata = d;
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  initial begin
    fork
      begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none
    idle(3);
    // R3: reset state
    chk("R3 reset rdata", rdata, 8'h00);
    rst_n = 1;
    idle(5);
    // R4: each defined divider code
    for (int s = 0; s < 7; s++) begin
      wr(8'(s));
      idle(140);
    end
    // R2: unimplemented bits written high
    wr(8'h2D);
    idle(10);
    // R5: undefined code, then back to a legal one
    wr(8'h07);
    idle(140);
    wr(8'h01);
    idle(20);
    // R6: route without bandgap request
    wr(8'h80);
    idle(10);
    // R7: supervisors alone
    lvr_en = 1; idle(5); lvr_en = 0; lvd_en = 1; idle(5); lvd_en = 0;
    // R9: requests with bandgap off
    conv_req = 1; idle(4); conv_req = 0;
    // R8/R9: enable, request during settle, abort mid-settle, re-enable
    wr(8'h40);
    conv_req = 1; idle(8);
    wr(8'h00);
    idle(3);
    wr(8'hC2);
    idle(SETTLE + 10);
    conv_req = 0; idle(3);
    // back-to-back clear then set
    wr(8'h00);
    wr(8'h50);
    conv_req = 1; idle(SETTLE + 5); conv_req = 0;
    // R10
    wr(8'h10); idle(5);
    wr(8'hFF); idle(30);
    // R3: reset mid-run
    rst_n = 0; idle(3);
    chk("R3 reset mid-run rdata", rdata, 8'h00);
    rst_n = 1; idle(10);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule